// File: doc/BRIEF.md
# Racing-Path Response Recombiner

This block sits behind a set of emulated multiplexer-chain delay lines. Each of N parallel chains delivers two racing paths, so the block sees 2N arrival times, each a small unsigned number. Smaller means earlier. The block turns these times into a response word whose meaning depends on a configuration chosen for each request. Changing the configuration changes the challenge-response behaviour without touching the chains themselves.

Two modes exist. In pair mode, an enumerated code picks an ordered pair of distinct paths, and a single arbiter decides which of the two arrived first. In neighbour mode, a fixed bank of 2N-1 arbiters compares every path with the next one. No comparison wraps from the last path back to the first. The comparison bits are packed into the response word.

A small controller registers the outcome one cycle after each request. It then reports one of three things: a valid response, a rejection, or nothing.

Top module: `path_recomb_unit`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `out_valid` and `out_err` are 0 and `out_resp` is all zeros.
- R2: A request (`in_valid`=1 with a legal configuration) sampled at a clock edge makes `out_valid` 1 and `out_err` 0 during the following cycle. A request in each of several back-to-back cycles yields one response per cycle.
- R3: Pair mode is `cfg_mode`=0. The code c selects the first path f = c / (2N-1). With k = c mod (2N-1), the second path is s = k when k < f, and s = k+1 otherwise. `out_resp[0]` is 1 exactly when path f arrives strictly earlier than path s. All higher response bits are 0. With N=2 the twelve codes 0..11 each give a different ordered pair.
- R4: Neighbour mode is `cfg_mode`=1. `out_resp[i]` is 1 exactly when path i arrives strictly earlier than path i+1, for i = 0..2N-2. There is no comparison of path 2N-1 against path 0.
- R5: Equal arrival times make the affected arbiter bit 0, in both modes.
- R6: A pair-mode request whose code is 2N(2N-1) or above (12..15 for N=2) is rejected. In the next cycle `out_err` is 1 and `out_valid` is 0, and `out_resp` keeps its previous value.
- R7: In neighbour mode the code is ignored. A request carrying an out-of-range code is still answered normally, with no error.
- R8: A cycle without `in_valid` leaves `out_valid` and `out_err` at 0 in the next cycle. `out_resp` changes only in a cycle where `out_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| arrival | input | 2N*TIME_W | Arrival times; path i occupies bits [i*TIME_W +: TIME_W] |
| cfg_mode | input | 1 | 0 = pair mode, 1 = neighbour mode |
| cfg_code | input | CODE_W | Ordered-pair code used in pair mode (4 bits for N=2) |
| out_valid | output | 1 | Response valid, one cycle after the request |
| out_resp | output | 2N-1 | Response word |
| out_err | output | 1 | Configuration rejected, one cycle after the request |

The controller has three states: IDLE, EMIT and REJECT. From any state, the next state is chosen as follows:
- A legal request leads to EMIT (transition ACCEPT).
- A pair-mode request with an illegal code leads to REJECT (transition REFUSE).
- No request leads to IDLE (transition QUIET).

## Verification
The hardest behaviour to reach from the ports is a rejection, or an idle cycle, that follows a response. It must leave the previously registered response word untouched. The stimulus first loads a known, non-zero neighbour response and then issues out-of-range pair codes. It checks that the same word is still present while the error flag is raised. Ties are placed on exactly the compared pair, and an out-of-range code is sent in neighbour mode, so the validity checks on the code are exercised in both modes.

// File: rtl/rr_pkg.sv
package rr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_EMIT   = 2'd1,
        ST_REJECT = 2'd2
    } rr_state_e;

    typedef enum logic {
        MODE_PAIR  = 1'b0,
        MODE_NEIGH = 1'b1
    } rr_mode_e;

endpackage

// File: rtl/rr_arbiter.sv
module rr_arbiter #(
    parameter int TIME_W = 8
) (
    input  logic [TIME_W-1:0] t_first,
    input  logic [TIME_W-1:0] t_second,
    output logic              first_wins
);
    // strict comparison: a tie goes to 0
    assign first_wins = (t_first < t_second);
endmodule

// File: rtl/rr_pair_decode.sv
module rr_pair_decode #(
    parameter int NPATH  = 4,
    parameter int CODE_W = 4,
    parameter int IDX_W  = 2
) (
    input  logic [CODE_W-1:0] code,
    output logic [IDX_W-1:0]  first_idx,
    output logic [IDX_W-1:0]  second_idx,
    output logic              legal
);
    always_comb begin
        first_idx  = '0;
        second_idx = '0;
        legal      = 1'b0;
        for (int f = 0; f < NPATH; f++) begin
            for (int s = 0; s < NPATH; s++) begin
                if (f != s) begin
                    if (code == CODE_W'(f * (NPATH - 1) + ((s < f) ? s : s - 1))) begin
                        first_idx  = IDX_W'(f);
                        second_idx = IDX_W'(s);
                        legal      = 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/rr_ctrl_fsm.sv
module rr_ctrl_fsm
    import rr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic cfg_ok,
    output logic load_resp,
    output logic valid_o,
    output logic err_o
);
    rr_state_e state_q, state_d;

    always_comb begin
        if (req && cfg_ok) begin
            state_d = ST_EMIT;        // ACCEPT
        end else if (req) begin
            state_d = ST_REJECT;      // REFUSE
        end else begin
            state_d = ST_IDLE;        // QUIET
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign load_resp = (state_d == ST_EMIT);

    always_comb begin
        valid_o = 1'b0;
        err_o   = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_EMIT:   valid_o = 1'b1;
            ST_REJECT: err_o   = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/path_recomb_unit.sv
module path_recomb_unit
    import rr_pkg::*;
#(
    parameter int N_CHAINS = 2,
    parameter int TIME_W   = 8,
    localparam int NPATH   = 2 * N_CHAINS,
    localparam int NPAIR   = NPATH * (NPATH - 1),
    localparam int CODE_W  = $clog2(NPAIR),
    localparam int IDX_W   = $clog2(NPATH),
    localparam int RESP_W  = NPATH - 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [NPATH*TIME_W-1:0] arrival,
    input  logic                    cfg_mode,
    input  logic [CODE_W-1:0]       cfg_code,
    output logic                    out_valid,
    output logic [RESP_W-1:0]       out_resp,
    output logic                    out_err
);
    logic [TIME_W-1:0] path_t [NPATH];
    logic [RESP_W-1:0] neigh_bits;
    logic [IDX_W-1:0]  first_idx, second_idx;
    logic              pair_legal, pair_bit, cfg_ok, load_resp;
    logic [RESP_W-1:0] resp_d, resp_q;

    for (genvar i = 0; i < NPATH; i++) begin : g_unpack
        assign path_t[i] = arrival[i*TIME_W +: TIME_W];
    end

    // non-cyclic neighbour bank
    for (genvar i = 0; i < RESP_W; i++) begin : g_neigh
        rr_arbiter #(.TIME_W(TIME_W)) i_arb (
            .t_first    (path_t[i]),
            .t_second   (path_t[i+1]),
            .first_wins (neigh_bits[i])
        );
    end

    rr_pair_decode #(.NPATH(NPATH), .CODE_W(CODE_W), .IDX_W(IDX_W)) i_dec (
        .code       (cfg_code),
        .first_idx  (first_idx),
        .second_idx (second_idx),
        .legal      (pair_legal)
    );

    rr_arbiter #(.TIME_W(TIME_W)) i_pair_arb (
        .t_first    (path_t[first_idx]),
        .t_second   (path_t[second_idx]),
        .first_wins (pair_bit)
    );

    assign cfg_ok = (rr_mode_e'(cfg_mode) == MODE_NEIGH) || pair_legal;

    always_comb begin
        if (rr_mode_e'(cfg_mode) == MODE_NEIGH) begin
            resp_d = neigh_bits;
        end else begin
            resp_d = {{(RESP_W-1){1'b0}}, pair_bit};
        end
    end

    rr_ctrl_fsm i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (in_valid),
        .cfg_ok    (cfg_ok),
        .load_resp (load_resp),
        .valid_o   (out_valid),
        .err_o     (out_err)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_q <= '0;
        end else if (load_resp) begin
            resp_q <= resp_d;
        end
    end

    assign out_resp = resp_q;
endmodule

// File: rtl/path_recomb_checker.sv
module path_recomb_checker #(
    parameter int N_CHAINS = 2,
    parameter int TIME_W   = 8,
    localparam int NPATH   = 2 * N_CHAINS,
    localparam int NPAIR   = NPATH * (NPATH - 1),
    localparam int CODE_W  = $clog2(NPAIR),
    localparam int RESP_W  = NPATH - 1
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic [NPATH*TIME_W-1:0] arrival,
    input logic                    cfg_mode,
    input logic [CODE_W-1:0]       cfg_code,
    input logic                    out_valid,
    input logic [RESP_W-1:0]       out_resp,
    input logic                    out_err
);
    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !out_valid && !out_err && out_resp == '0); // R1
    AST_ACCEPT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (cfg_mode || 32'(cfg_code) < NPAIR) |=> out_valid && !out_err); // R2
    AST_PAIR_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !cfg_mode && 32'(cfg_code) < NPAIR |=> (out_resp >> 1) == '0); // R3
    AST_NEIGH_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && cfg_mode |=> out_resp[0] == ($past(arrival[TIME_W-1:0]) < $past(arrival[2*TIME_W-1:TIME_W]))); // R4
    AST_REFUSE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !cfg_mode && 32'(cfg_code) >= NPAIR |=> out_err && !out_valid); // R6
    AST_NEIGH_CODE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && cfg_mode |=> !out_err); // R7
    AST_IDLE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && !out_err); // R8
    AST_RESP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid && $past(rst_n) |-> $stable(out_resp)); // R8
    AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_valid, out_err})); // R6
endmodule

bind path_recomb_unit path_recomb_checker #(.N_CHAINS(N_CHAINS), .TIME_W(TIME_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .arrival   (arrival),
    .cfg_mode  (cfg_mode),
    .cfg_code  (cfg_code),
    .out_valid (out_valid),
    .out_resp  (out_resp),
    .out_err   (out_err)
);

// File: tb/test_path_recomb_unit.sv
module test_path_recomb_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] arrival;
    logic        cfg_mode;
    logic [3:0]  cfg_code;
    logic        out_valid;
    logic [2:0]  out_resp;
    logic        out_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    path_recomb_unit #(.N_CHAINS(2), .TIME_W(8)) i_path_recomb_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .arrival   (arrival),
        .cfg_mode  (cfg_mode),
        .cfg_code  (cfg_code),
        .out_valid (out_valid),
        .out_resp  (out_resp),
        .out_err   (out_err)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive at negedge, sample at the next negedge (one rising edge later)
    task automatic send(input bit v, input bit mode, input int code,
                        input int t0, input int t1, input int t2, input int t3);
        in_valid = v;
        cfg_mode = mode;
        cfg_code = 4'(code);
        arrival  = {8'(t3), 8'(t2), 8'(t1), 8'(t0)};
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; in_valid = 1'b0; cfg_mode = 1'b0; cfg_code = '0; arrival = '0;
        repeat (3) @(negedge clk);
        check("R1 valid", int'(out_valid), 0);
        check("R1 err", int'(out_err), 0);
        check("R1 resp", int'(out_resp), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after release", int'(out_valid), 0);
    endtask

    task automatic t_pair_all_codes();
        int t [4] = '{10, 40, 20, 30};
        for (int c = 0; c < 12; c++) begin
            int f = c / 3;
            int k = c % 3;
            int s = (k < f) ? k : k + 1;
            send(1'b1, 1'b0, c, t[0], t[1], t[2], t[3]);
            check("R3 pair resp", int'(out_resp), (t[f] < t[s]) ? 1 : 0);
            check("R2 valid", int'(out_valid), 1);
            check("R2 err", int'(out_err), 0);
        end
    endtask

    task automatic t_pair_tie();
        send(1'b1, 1'b0, 0, 25, 25, 5, 5);     // code 0: path0 vs path1, tied
        check("R5 pair tie", int'(out_resp), 0);
        send(1'b1, 1'b0, 3, 25, 26, 9, 9);     // code 3: path1 vs path0 -> 26<25 false
        check("R3 reverse pair", int'(out_resp), 0);
        send(1'b1, 1'b0, 4, 30, 26, 90, 9);    // code 4: path1 vs path2 -> 1
        check("R3 pair 1v2", int'(out_resp), 1);
    endtask

    task automatic t_neighbour();
        send(1'b1, 1'b1, 0, 1, 2, 3, 4);       // all earlier than next
        check("R4 ascending", int'(out_resp), 7);
        send(1'b1, 1'b1, 0, 4, 3, 2, 1);
        check("R4 descending", int'(out_resp), 0);
        send(1'b1, 1'b1, 0, 9, 50, 5, 200);    // 9<50,50<5 no,5<200 -> 101
        check("R4 mixed", int'(out_resp), 5);
        send(1'b1, 1'b1, 0, 7, 7, 7, 1);       // ties; last earlier than first ignored
        check("R5 neighbour tie / R4 non-cyclic", int'(out_resp), 0);
    endtask

    task automatic t_back_to_back();
        in_valid = 1'b1; cfg_mode = 1'b1; cfg_code = '0;
        arrival = {8'd4, 8'd3, 8'd2, 8'd1};
        @(negedge clk);
        check("R2 b2b first", int'(out_resp), 7);
        arrival = {8'd1, 8'd3, 8'd2, 8'd1};
        @(negedge clk);
        check("R2 b2b second", int'(out_resp), 3);
        check("R2 b2b valid", int'(out_valid), 1);
        in_valid = 1'b0;
        @(negedge clk);
        check("R8 idle valid", int'(out_valid), 0);
        check("R8 idle err", int'(out_err), 0);
        check("R8 idle resp hold", int'(out_resp), 3);
    endtask

    task automatic t_reject();
        send(1'b1, 1'b1, 0, 1, 2, 1, 2);       // load 101
        check("R4 preload", int'(out_resp), 5);
        for (int c = 12; c < 16; c++) begin
            send(1'b1, 1'b0, c, 1, 2, 3, 4);
            check("R6 err", int'(out_err), 1);
            check("R6 no valid", int'(out_valid), 0);
            check("R6 resp held", int'(out_resp), 5);
        end
        send(1'b1, 1'b1, 15, 4, 3, 2, 1);      // illegal code, neighbour mode
        check("R7 valid", int'(out_valid), 1);
        check("R7 no err", int'(out_err), 0);
        check("R7 resp", int'(out_resp), 0);
        @(negedge clk);
        check("R8 quiet after", int'(out_valid) + int'(out_err), 0);
    endtask

    initial begin
        t_reset();
        t_pair_all_codes();
        t_pair_tie();
        t_neighbour();
        t_back_to_back();
        t_reject();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule